// File: doc/BRIEF.md
# Battery Charge Sequence Controller

This block steps a handset battery through charging, from the moment a charger is plugged in until the charge is finished. It reads four things: a flag that says a charger is present, a flag that says whether the source is a USB 2.0 port or a dedicated wall charger, the battery voltage in millivolts, and a one-cycle pulse from the current regulator that marks a change between constant-current and constant-voltage operation. It drives the charge voltage target, the main and trickle current selections, the battery isolation switch, a request to start the host processor and a charge-complete flag. The current regulators and the voltage converter sit outside the block. The block only chooses their settings.

On a dedicated charger the sequence works as follows. The controller first runs at full rate with the battery switch open and the voltage clamped low. It trickles a deep-discharged cell until the cell recovers. It then raises the voltage target, closes the switch for standard charging, and stops on the first regulator mode-change event at which the cell is high enough. On a USB port the controller uses a low fixed rate. It stops when a tick-counted timeout expires or when the cell reaches the low clamp voltage. It wakes the processor only once the cell can carry the processor's load. An overvoltage cell forces every current off. Unplugging the charger returns the block to idle from any state.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset, and while no charger is present, all outputs are 0: voltage target code 0, main code 0, trickle off, switch open, no start request, no completion.
- R2: One clock after a dedicated charger (type flag 0) appears with the battery at or below 4200 mV, the outputs are: voltage target code 1 (4.05 V clamp), main code 2 (full rate), trickle off, switch open (0), start request 1.
- R3: On the next clock, a battery below 3400 mV selects trickle (trickle 1, main 0, target code 1). Trickle continues until the battery reaches 3400 mV. A battery at or above 3400 mV selects target code 2 (4.2 V) with trickle 1 and main 0.
- R4: While the target is code 2 and the switch is open, a battery at or below 3200 mV keeps trickle on. One clock after the battery is above 3200 mV, the switch closes (1), main is code 2 and trickle is off.
- R5: During standard charging, a mode-change pulse with the battery above 4150 mV ends the charge: the completion flag is 1 and the main current, trickle and target are all 0. A pulse at or below 4150 mV, or no pulse at all, leaves charging unchanged.
- R6: One clock after a USB charger (type flag 1) appears, the outputs are: target code 1, main code 1 (70 mA), trickle off, switch open, and no completion.
- R7: On the USB path the start request rises one clock after the battery is seen at or above 3400 mV. It never rises below 3400 mV. Once raised it stays at 1 until the charger is removed.
- R8: USB charging ends with completion set once TIMEOUT_TICKS tick pulses have been counted. It ends earlier if the battery reaches 4050 mV.
- R9: A battery above 4200 mV while a charger is present and charging is not complete forces, one clock later, main 0, trickle 0, target 0, switch open and completion 0. This state holds until the charger is removed.
- R10: One clock after the charger is removed, the block is idle with all outputs 0, whatever state it was in. The USB tick count restarts from zero on the next insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_present | input | 1 | A charger source is attached |
| chg_is_usb | input | 1 | 1 = USB 2.0 port, 0 = dedicated charger |
| batt_mv | input | VW | Battery voltage in millivolts |
| mode_evt | input | 1 | One-cycle pulse on a CC/CV regulation mode change |
| tick | input | 1 | One-cycle time base pulse for the USB timeout |
| vtarget_sel | output | 2 | 0 = none, 1 = 4.05 V clamp, 2 = 4.2 V |
| main_sel | output | 2 | 0 = off, 1 = USB low rate, 2 = full rate |
| trickle_on | output | 1 | Trickle current source enabled |
| batt_sw_closed | output | 1 | Battery isolation switch closed |
| cpu_start | output | 1 | Request to start the host processor |
| chg_done | output | 1 | Charging completed |

## Verification
The dedicated-charger path is swept over a list of battery voltages that straddle every threshold by one millivolt: 3200, 3400, 4150 and 4200. Each point shows whether that comparison is strict or inclusive, and whether the cell trickles, goes to fast charge, completes or faults. The USB path is swept across the 3400 mV and 4050 mV edges, which separates the wake-up decision from the stop decision. The tick timeout is tested one tick short of the limit and exactly at it, both before and after an unplug, to show that removal clears the count. Further runs cover a sag below 3200 mV after the target is raised, a mode-change pulse at or below the completion threshold, and an overvoltage during standard charging, which checks that fault entry takes priority and that only removal leaves the fault state.

// File: rtl/chg_seq_pkg.sv
// Shared state type and output code values for the charge sequence controller.
// Assumes two-bit codes suffice for the voltage and current selections.
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DC_PRE,
        ST_DC_TRK,
        ST_DC_RAISE,
        ST_DC_FAST,
        ST_USB,
        ST_DONE,
        ST_FAULT
    } chg_state_t;

    localparam logic [1:0] VT_NONE  = 2'd0;
    localparam logic [1:0] VT_CLAMP = 2'd1;
    localparam logic [1:0] VT_FULL  = 2'd2;

    localparam logic [1:0] CUR_OFF  = 2'd0;
    localparam logic [1:0] CUR_USB  = 2'd1;
    localparam logic [1:0] CUR_FULL = 2'd2;

endpackage

// File: rtl/chg_thresh.sv
// Voltage comparator bank: turns the battery reading into the decision flags
// used by the sequencer. Assumes thresholds are given in the same millivolt
// units as the reading and that they fit in VW bits.
module chg_thresh #(
    parameter int VW        = 13,
    parameter int TRK_MV    = 3400,
    parameter int SW_MV     = 3200,
    parameter int DONE_MV   = 4150,
    parameter int USBSTP_MV = 4050,
    parameter int OVP_MV    = 4200
) (
    input  logic [VW-1:0] batt_mv,
    output logic          lt_trk,
    output logic          gt_sw,
    output logic          gt_done,
    output logic          ge_usbstop,
    output logic          gt_max
);

    localparam logic [VW-1:0] TRK_L  = VW'(TRK_MV);
    localparam logic [VW-1:0] SW_L   = VW'(SW_MV);
    localparam logic [VW-1:0] DONE_L = VW'(DONE_MV);
    localparam logic [VW-1:0] USB_L  = VW'(USBSTP_MV);
    localparam logic [VW-1:0] OVP_L  = VW'(OVP_MV);

    // Compare the reading against each fixed threshold.
    always_comb begin
        lt_trk     = batt_mv <  TRK_L;
        gt_sw      = batt_mv >  SW_L;
        gt_done    = batt_mv >  DONE_L;
        ge_usbstop = batt_mv >= USB_L;
        gt_max     = batt_mv >  OVP_L;
    end

endmodule

// File: rtl/chg_usb_timer.sv
// USB charge timeout: counts tick pulses while run is high and clears
// whenever run is low. Assumes tick is one cycle wide and LIMIT >= 1.
module chg_usb_timer #(
    parameter int LIMIT = 5400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count ticks up to the limit while running, otherwise restart at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick && cnt != LIM_C)
            cnt <= cnt + 1'b1;
    end

    // Flag the limit once it has been reached.
    always_comb expired = (cnt == LIM_C);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_C); // R8

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0); // R10

endmodule

// File: rtl/chg_seq_fsm.sv
// Charge sequencer: walks dedicated and USB charging flows, applies the
// overvoltage and removal overrides, and decodes the output settings.
// Assumes threshold flags and the timer flag are valid in the same cycle.
module chg_seq_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_present,
    input  logic       chg_is_usb,
    input  logic       mode_evt,
    input  logic       lt_trk,
    input  logic       gt_sw,
    input  logic       gt_done,
    input  logic       ge_usbstop,
    input  logic       gt_max,
    input  logic       tmr_expired,
    output chg_state_t state,
    output logic       cpu_start,
    output logic [1:0] vtarget_sel,
    output logic [1:0] main_sel,
    output logic       trickle_on,
    output logic       batt_sw_closed,
    output logic       chg_done
);

    chg_state_t nxt;

    // Pick the next state: removal first, then overvoltage, then the flow.
    always_comb begin
        nxt = state;
        if (!chg_present)
            nxt = ST_IDLE;
        else if (gt_max && state != ST_DONE)
            nxt = ST_FAULT;
        else begin
            case (state)
                ST_IDLE:     nxt = chg_is_usb ? ST_USB : ST_DC_PRE;
                ST_DC_PRE:   nxt = lt_trk ? ST_DC_TRK : ST_DC_RAISE;
                ST_DC_TRK:   if (!lt_trk) nxt = ST_DC_RAISE;
                ST_DC_RAISE: if (gt_sw) nxt = ST_DC_FAST;
                ST_DC_FAST:  if (mode_evt && gt_done) nxt = ST_DONE;
                ST_USB:      if (tmr_expired || ge_usbstop) nxt = ST_DONE;
                default:     nxt = state;
            endcase
        end
    end

    // Hold the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Sticky processor start request, dropped only on removal.
    always_ff @(posedge clk) begin
        if (!rst_n || !chg_present)
            cpu_start <= 1'b0;
        else if ((state == ST_IDLE && !chg_is_usb && !gt_max) ||
                 (state == ST_USB && !lt_trk))
            cpu_start <= 1'b1;
    end

    // Decode the regulator settings from the current state.
    always_comb begin
        vtarget_sel    = VT_NONE;
        main_sel       = CUR_OFF;
        trickle_on     = 1'b0;
        batt_sw_closed = 1'b0;
        chg_done       = 1'b0;
        case (state)
            ST_DC_PRE:   begin vtarget_sel = VT_CLAMP; main_sel = CUR_FULL; end
            ST_DC_TRK:   begin vtarget_sel = VT_CLAMP; trickle_on = 1'b1; end
            ST_DC_RAISE: begin vtarget_sel = VT_FULL;  trickle_on = 1'b1; end
            ST_DC_FAST:  begin vtarget_sel = VT_FULL;  main_sel = CUR_FULL;
                               batt_sw_closed = 1'b1; end
            ST_USB:      begin vtarget_sel = VT_CLAMP; main_sel = CUR_USB; end
            ST_DONE:     chg_done = 1'b1;
            default:     ;
        endcase
    end

    AST_REMOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_present |=> (state == ST_IDLE && !cpu_start)); // R10

    AST_LOW_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DC_FAST && chg_present && mode_evt && !gt_done && !gt_max)
        |=> state == ST_DC_FAST); // R5

    AST_USB_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_USB && chg_present && lt_trk && !cpu_start) |=> !cpu_start); // R7

    AST_FAULT_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && chg_present) |=> state == ST_FAULT); // R9

endmodule

// File: rtl/chg_seq_ctrl.sv
// Top of the battery charge sequence controller: joins the comparator bank,
// the USB timeout counter and the sequencer. Assumes batt_mv is a settled
// synchronous sample and that mode_evt and tick are single-cycle pulses.
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int VW            = 13,
    parameter int TRK_MV        = 3400,
    parameter int SW_MV         = 3200,
    parameter int DONE_MV       = 4150,
    parameter int USBSTP_MV     = 4050,
    parameter int OVP_MV        = 4200,
    parameter int TIMEOUT_TICKS = 5400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chg_present,
    input  logic          chg_is_usb,
    input  logic [VW-1:0] batt_mv,
    input  logic          mode_evt,
    input  logic          tick,
    output logic [1:0]    vtarget_sel,
    output logic [1:0]    main_sel,
    output logic          trickle_on,
    output logic          batt_sw_closed,
    output logic          cpu_start,
    output logic          chg_done
);

    logic       lt_trk, gt_sw, gt_done, ge_usbstop, gt_max, tmr_expired;
    chg_state_t state;
    logic       usb_run;

    chg_thresh #(
        .VW(VW), .TRK_MV(TRK_MV), .SW_MV(SW_MV), .DONE_MV(DONE_MV),
        .USBSTP_MV(USBSTP_MV), .OVP_MV(OVP_MV)
    ) u_thresh (
        .batt_mv(batt_mv), .lt_trk(lt_trk), .gt_sw(gt_sw), .gt_done(gt_done),
        .ge_usbstop(ge_usbstop), .gt_max(gt_max)
    );

    // Run the timeout only while in the USB charging state.
    always_comb usb_run = (state == ST_USB);

    chg_usb_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(usb_run), .tick(tick),
        .expired(tmr_expired)
    );

    chg_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .chg_present(chg_present),
        .chg_is_usb(chg_is_usb), .mode_evt(mode_evt), .lt_trk(lt_trk),
        .gt_sw(gt_sw), .gt_done(gt_done), .ge_usbstop(ge_usbstop),
        .gt_max(gt_max), .tmr_expired(tmr_expired), .state(state),
        .cpu_start(cpu_start), .vtarget_sel(vtarget_sel), .main_sel(main_sel),
        .trickle_on(trickle_on), .batt_sw_closed(batt_sw_closed),
        .chg_done(chg_done)
    );

    AST_OVP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_present && gt_max) |=> (main_sel == CUR_OFF && !trickle_on)); // R9

    AST_SW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_sw_closed) |-> $past(batt_mv) > VW'(SW_MV)); // R4

endmodule

// File: tb/sim_chg_seq_ctrl.sv
module sim_chg_seq_ctrl;

    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chg_present = 1'b0;
    logic        chg_is_usb = 1'b0;
    logic [12:0] batt_mv = 13'd3000;
    logic        mode_evt = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  vtarget_sel, main_sel;
    logic        trickle_on, batt_sw_closed, cpu_start, chg_done;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    chg_seq_ctrl #(.TIMEOUT_TICKS(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .chg_present(chg_present),
        .chg_is_usb(chg_is_usb), .batt_mv(batt_mv), .mode_evt(mode_evt),
        .tick(tick), .vtarget_sel(vtarget_sel), .main_sel(main_sel),
        .trickle_on(trickle_on), .batt_sw_closed(batt_sw_closed),
        .cpu_start(cpu_start), .chg_done(chg_done)
    );

    function automatic logic [7:0] pk(input int vt, input int mn, input bit trk,
                                      input bit sw, input bit cpu, input bit dn);
        return {2'(vt), 2'(mn), trk, sw, cpu, dn};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ck(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {vtarget_sel, main_sel, trickle_on, batt_sw_closed, cpu_start, chg_done};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s batt=%0d actual=%b expected=%b", req, batt_mv, act, exp);
        end
    endtask

    task automatic unplug();
        chg_present = 1'b0;
        cyc(1);
        ck("R10 idle after removal", pk(0,0,0,0,0,0));
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
    endtask

    int dc_v[12] = '{3000, 3199, 3200, 3201, 3399, 3400, 3800, 4149, 4150, 4151, 4200, 4201};
    int usb_v[6] = '{3300, 3399, 3400, 3500, 4049, 4050};

    initial begin
        cyc(3);
        ck("R1 reset state", pk(0,0,0,0,0,0));
        rst_n = 1'b1;
        cyc(2);
        ck("R1 idle no charger", pk(0,0,0,0,0,0));

        // Dedicated-charger sweep over threshold edges.
        foreach (dc_v[i]) begin
            int v;
            v = dc_v[i];
            batt_mv = 13'(v);
            chg_is_usb = 1'b0;
            chg_present = 1'b1;
            cyc(1);
            if (v > 4200) begin
                ck("R9 overvoltage at insertion", pk(0,0,0,0,0,0));
                cyc(3);
                ck("R9 fault holds", pk(0,0,0,0,0,0));
            end else begin
                ck("R2 dedicated entry", pk(1,2,0,0,1,0));
                cyc(1);
                if (v < 3400) ck("R3 trickle below 3400", pk(1,0,1,0,1,0));
                else          ck("R3 raise target", pk(2,0,1,0,1,0));
                cyc(1);
                if (v < 3400) ck("R3 trickle continues", pk(1,0,1,0,1,0));
                else          ck("R4 standard charge", pk(2,2,0,1,1,0));
                cyc(3);
                if (v < 3400) ck("R5 no event stays", pk(1,0,1,0,1,0));
                else          ck("R5 no event stays", pk(2,2,0,1,1,0));
                mode_evt = 1'b1;
                cyc(1);
                mode_evt = 1'b0;
                if (v < 3400)      ck("R5 event ignored in trickle", pk(1,0,1,0,1,0));
                else if (v > 4150) ck("R5 complete", pk(0,0,0,0,1,1));
                else               ck("R5 low event continues", pk(2,2,0,1,1,0));
            end
            unplug();
        end

        // Recovery from trickle and sag below the switch threshold.
        batt_mv = 13'd3300;
        chg_present = 1'b1;
        cyc(2);
        ck("R3 trickle at 3300", pk(1,0,1,0,1,0));
        batt_mv = 13'd3400;
        cyc(1);
        ck("R3 recover to raise", pk(2,0,1,0,1,0));
        batt_mv = 13'd3100;
        cyc(2);
        ck("R4 sag keeps trickle", pk(2,0,1,0,1,0));
        batt_mv = 13'd3200;
        cyc(1);
        ck("R4 at 3200 stays open", pk(2,0,1,0,1,0));
        batt_mv = 13'd3201;
        cyc(1);
        ck("R4 switch closes", pk(2,2,0,1,1,0));
        batt_mv = 13'd4201;
        cyc(1);
        ck("R9 overvoltage in charge", pk(0,0,0,0,1,0));
        batt_mv = 13'd3800;
        mode_evt = 1'b1;
        cyc(1);
        mode_evt = 1'b0;
        cyc(1);
        ck("R9 fault latched", pk(0,0,0,0,1,0));
        unplug();

        // USB sweep across wake and stop edges.
        foreach (usb_v[i]) begin
            int v;
            v = usb_v[i];
            batt_mv = 13'(v);
            chg_is_usb = 1'b1;
            chg_present = 1'b1;
            cyc(1);
            ck("R6 usb entry", pk(1,1,0,0,0,0));
            cyc(1);
            if (v >= 4050)      ck("R8 usb stop at 4050", pk(0,0,0,0,1,1));
            else if (v >= 3400) ck("R7 usb wake", pk(1,1,0,0,1,0));
            else                ck("R7 usb no wake", pk(1,1,0,0,0,0));
            unplug();
        end

        // Sticky wake after voltage drops.
        batt_mv = 13'd3450;
        chg_present = 1'b1;
        cyc(2);
        batt_mv = 13'd3350;
        cyc(2);
        ck("R7 wake is sticky", pk(1,1,0,0,1,0));
        unplug();

        // Timeout short by one, removal clears, then exact.
        batt_mv = 13'd3500;
        chg_present = 1'b1;
        cyc(1);
        for (int k = 0; k < LIM - 1; k++) pulse_tick();
        cyc(3);
        ck("R8 one tick short", pk(1,1,0,0,1,0));
        unplug();
        chg_present = 1'b1;
        cyc(1);
        for (int k = 0; k < LIM - 1; k++) pulse_tick();
        cyc(3);
        ck("R10 count cleared by removal", pk(1,1,0,0,1,0));
        pulse_tick();
        cyc(1);
        ck("R8 timeout complete", pk(0,0,0,0,1,1));
        unplug();

        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule